// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block turns single-word host requests into command sequences for a four-bank, 32-bit synchronous DRAM. A request carries a flat word address, a write flag, write data and byte enables. The controller slices the address into bank, row and column. It opens the row with ACTIVE, then issues one READ or WRITE with auto-precharge set, and it waits the recovery time before it accepts the next request. Every access therefore leaves all banks closed.

After reset the controller holds the device in NOP for a programmable start-up interval. It then runs a fixed wake-up sequence that ends by loading the mode register. After that it inserts AUTO REFRESH commands at a fixed interval. Read data comes back on a separate return port once the programmed CAS latency has passed. The latency is a parameter and may be 2 or 3. All device pins come from registers. The data bus is split into an output half with an enable and an input half.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low and the pins show NOP for at least `INIT_CYC` cycles. The controller then issues exactly PRECHARGE (with A10=1), AUTO REFRESH, AUTO REFRESH and LOAD MODE, in that order. No other command and no high `req_ready` comes before the sequence is complete.
- R2: The LOAD MODE command puts the CAS latency (2 or 3) on A[6:4] and sets A9=1 (single-location writes). A[2:0]=000 selects one-word bursts and A3=0 selects sequential order. Every other address bit is 0.
- R3: Host address bits [7:0] form the column, bits [19:8] the row and bits [21:20] the bank. ACTIVE carries the bank on BA and the row on A. The following column command carries the same bank and puts the column on A[7:0].
- R4: Every READ and WRITE has A10=1 (auto-precharge). All other address bits above the column are 0.
- R5: For each READ, `rd_valid` pulses for one cycle with `rd_data` holding the bus value sampled CAS latency clocks after the edge that took the READ. The pulse is visible CAS latency + 1 cycles after the READ appears on the pins. Results return in request order.
- R6: During the WRITE cycle, `sd_dq_oe` is 1, `sd_dq_out` carries the write data and `sd_dqm[i]` = NOT `req_be[i]`, so a 1 masks byte lane i (bits 8i+7:8i). `sd_dq_oe` is 0 in every other cycle.
- R7: During a READ, all `sd_dqm` bits are 0 and `sd_dq_oe` is 0.
- R8: Timing rules:
  - A column command follows its ACTIVE after at least `T_RCD` cycles.
  - ACTIVE or AUTO REFRESH comes at least `T_RC` cycles after any earlier ACTIVE or AUTO REFRESH.
  - After a READ, the next ACTIVE or AUTO REFRESH waits at least max(CAS latency+`T_RP`, `T_RC`-`T_RCD`) cycles.
  - After a WRITE, the next ACTIVE or AUTO REFRESH waits at least max(`T_WR`+`T_RP`, `T_RC`-`T_RCD`) cycles.
- R9: Once initialised, the controller raises a refresh request every `REF_CYC` cycles. While the block is idle, successive AUTO REFRESH commands are exactly `REF_CYC` cycles apart. A pending refresh is issued before any new host request, so a gap never exceeds `REF_CYC` plus one access.
- R10: Commands use the active-low code {CS,RAS,CAS,WE}:

  | Command | Code |
  |---|---|
  | NOP | 0111 |
  | ACTIVE | 0011 |
  | READ | 0101 |
  | WRITE | 0100 |
  | PRECHARGE | 0010 |
  | AUTO REFRESH | 0001 |
  | LOAD MODE | 0000 |

  No other code appears.
- R11: `req_ready` is high only in the idle state with no refresh pending. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays low from then until that access has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Flat word address {bank,row,column} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Write byte enables |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Multiplexed address |
| sd_dqm | output | 4 | Byte mask / output disable |
| sd_dq_out | output | 32 | Data driven to the device |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 32 | Data returned by the device |

## Verification
The assertions check the following on every cycle:
- that auto-precharge is set on each column command;
- that a READ never carries a mask or drives the bus;
- that an idle controller with a pending refresh moves straight to the refresh state;
- that no refresh interval expires while the previous one is still unserved;
- that every read-valid pulse lies exactly latency+1 cycles behind a READ on the pins.

Only the bench scenarios can show the following:
- that address fields land on the right pins;
- that byte masks merge partial writes correctly;
- that the wake-up order and the spacing rules hold;
- that idle refresh spacing is exact and request-order data comes back.

The bench shows these by running a behavioural memory and a scoreboard against the pins.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   // active-low {cs, ras, cas, we}
   typedef enum logic [3:0] {
      CMD_MODE  = 4'b0000,
      CMD_REF   = 4'b0001,
      CMD_PRE   = 4'b0010,
      CMD_ACT   = 4'b0011,
      CMD_WRITE = 4'b0100,
      CMD_READ  = 4'b0101,
      CMD_NOP   = 4'b0111
   } sd_cmd_e;

   typedef enum logic [3:0] {
      ST_POWERUP,
      ST_PALL,
      ST_IREF,
      ST_LMR,
      ST_IDLE,
      ST_ACT,
      ST_COL,
      ST_REF,
      ST_WAIT
   } seq_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_seq_timer.sv
module sdram_seq_timer #(
   parameter int W       = 16,
   parameter int RST_VAL = 100
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sdram_seq_reftmr.sv
module sdram_seq_reftmr #(
   parameter int PERIOD = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic served,
   output logic pending
);

   localparam int CW = $clog2(PERIOD + 1);

   logic [CW-1:0] cnt_q;
   logic          tick;

   assign tick = run && (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= CW'(PERIOD - 1);
         pending <= 1'b0;
      end else begin
         if (run)
            cnt_q <= (cnt_q == '0) ? CW'(PERIOD - 1) : cnt_q - 1'b1;
         if (tick)
            pending <= 1'b1;
         else if (served)
            pending <= 1'b0;
      end
   end

   // a new interval must never expire while the previous one is unserved
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && pending && !served));

endmodule

// File: rtl/sdram_seq_rdpipe.sv
module sdram_seq_rdpipe #(
   parameter int LAT = 3,
   parameter int DW  = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic [DW-1:0] dq_in,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);

   logic [LAT-1:0] stage_q;

   for (genvar i = 0; i < LAT; i++) begin : g_stage
      if (i == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[0] <= 1'b0;
            else        stage_q[0] <= issue;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[i] <= 1'b0;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= stage_q[LAT-1];
         if (stage_q[LAT-1])
            rd_data <= dq_in;
      end
   end

   assert_rd_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(issue, LAT + 1));

endmodule

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl
   import sdram_seq_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int BANK_W   = 2,
   parameter int ROW_W    = 12,
   parameter int COL_W    = 8,
   parameter int CAS_LAT  = 3,
   parameter int INIT_CYC = 20000,
   parameter int REF_CYC  = 1560,
   parameter int T_RCD    = 2,
   parameter int T_RP     = 2,
   parameter int T_RC     = 7,
   parameter int T_MRD    = 2,
   parameter int T_WR     = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic                            req_we,
   input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]               req_wdata,
   input  logic [DATA_W/8-1:0]             req_be,
   output logic                            rd_valid,
   output logic [DATA_W-1:0]               rd_data,
   output logic                            sd_cs_n,
   output logic                            sd_ras_n,
   output logic                            sd_cas_n,
   output logic                            sd_we_n,
   output logic [BANK_W-1:0]               sd_ba,
   output logic [ROW_W-1:0]                sd_a,
   output logic [DATA_W/8-1:0]             sd_dqm,
   output logic [DATA_W-1:0]               sd_dq_out,
   output logic                            sd_dq_oe,
   input  logic [DATA_W-1:0]               sd_dq_in
);

   localparam int ADDR_W = BANK_W + ROW_W + COL_W;
   localparam int BE_W   = DATA_W / 8;
   localparam int RD_GAP = max2(CAS_LAT + T_RP, T_RC - T_RCD);
   localparam int WR_GAP = max2(T_WR + T_RP, T_RC - T_RCD);
   localparam int TMR_W  = $clog2(max2(INIT_CYC, 64) + 1);
   localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'((1 << 9) | (CAS_LAT << 4));

   // elaboration-time parameter checks
   if (CAS_LAT != 2 && CAS_LAT != 3) begin : g_bad_lat
      $error("CAS_LAT must be 2 or 3");
   end
   if (COL_W > 10 || ROW_W < 11) begin : g_bad_split
      $error("column must sit below A10 and row must reach A10");
   end
   if (T_RCD < 2 || T_RP < 2 || T_RC < 2 || T_MRD < 2 || T_WR < 1) begin : g_bad_tim
      $error("timing counts too small");
   end
   if (DATA_W % 8 != 0 || INIT_CYC < 2 || REF_CYC < 32) begin : g_bad_misc
      $error("width or interval out of range");
   end

   seq_state_e           st_q, st_d, ret_q, ret_d;
   logic                 iref_q, iref_d;
   logic                 init_done_q;
   logic                 tmr_ld, tmr_done, ref_pend, accept;
   logic [TMR_W-1:0]     tmr_val;
   logic                 r_we;
   logic [ADDR_W-1:0]    r_addr;
   logic [DATA_W-1:0]    r_wdata;
   logic [BE_W-1:0]      r_be;
   sd_cmd_e              cmd_d, cmd_q;
   logic [BANK_W-1:0]    ba_d;
   logic [ROW_W-1:0]     a_d;
   logic [BE_W-1:0]      dqm_d;
   logic                 oe_d;

   wire [BANK_W-1:0] f_bank = r_addr[ADDR_W-1 -: BANK_W];
   wire [ROW_W-1:0]  f_row  = r_addr[COL_W +: ROW_W];
   wire [COL_W-1:0]  f_col  = r_addr[0 +: COL_W];

   sdram_seq_timer #(.W(TMR_W), .RST_VAL(INIT_CYC - 1)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .done(tmr_done));

   sdram_seq_reftmr #(.PERIOD(REF_CYC)) u_ref (
      .clk(clk), .rst_n(rst_n), .run(init_done_q),
      .served(st_q == ST_REF), .pending(ref_pend));

   sdram_seq_rdpipe #(.LAT(CAS_LAT), .DW(DATA_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .issue(cmd_q == CMD_READ),
      .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data));

   assign req_ready = (st_q == ST_IDLE) && !ref_pend;
   assign accept    = req_ready && req_valid;

   always_comb begin
      st_d    = st_q;
      ret_d   = ret_q;
      iref_d  = iref_q;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      cmd_d   = CMD_NOP;
      ba_d    = '0;
      a_d     = '0;
      dqm_d   = '1;
      oe_d    = 1'b0;
      unique case (st_q)
         ST_POWERUP: if (tmr_done) st_d = ST_PALL;
         ST_PALL: begin
            cmd_d = CMD_PRE;  a_d[10] = 1'b1;
            tmr_ld = 1'b1;    tmr_val = TMR_W'(T_RP - 2);
            ret_d = ST_IREF;  st_d = ST_WAIT;
         end
         ST_IREF: begin
            cmd_d  = CMD_REF;
            tmr_ld = 1'b1;    tmr_val = TMR_W'(T_RC - 2);
            iref_d = ~iref_q;
            ret_d  = iref_q ? ST_LMR : ST_IREF;
            st_d   = ST_WAIT;
         end
         ST_LMR: begin
            cmd_d = CMD_MODE; a_d = MODE_WORD;
            tmr_ld = 1'b1;    tmr_val = TMR_W'(T_MRD - 2);
            ret_d = ST_IDLE;  st_d = ST_WAIT;
         end
         ST_IDLE: begin
            if (ref_pend)    st_d = ST_REF;
            else if (accept) st_d = ST_ACT;
         end
         ST_ACT: begin
            cmd_d = CMD_ACT;  ba_d = f_bank;  a_d = f_row;
            tmr_ld = 1'b1;    tmr_val = TMR_W'(T_RCD - 2);
            ret_d = ST_COL;   st_d = ST_WAIT;
         end
         ST_COL: begin
            cmd_d = r_we ? CMD_WRITE : CMD_READ;
            ba_d  = f_bank;
            a_d[COL_W-1:0] = f_col;
            a_d[10] = 1'b1;
            dqm_d = r_we ? ~r_be : '0;
            oe_d  = r_we;
            tmr_ld = 1'b1;
            tmr_val = r_we ? TMR_W'(WR_GAP - 2) : TMR_W'(RD_GAP - 2);
            ret_d = ST_IDLE;  st_d = ST_WAIT;
         end
         ST_REF: begin
            cmd_d = CMD_REF;
            tmr_ld = 1'b1;    tmr_val = TMR_W'(T_RC - 2);
            ret_d = ST_IDLE;  st_d = ST_WAIT;
         end
         ST_WAIT: if (tmr_done) st_d = ret_q;
         default: st_d = ST_POWERUP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_POWERUP;
         ret_q       <= ST_IDLE;
         iref_q      <= 1'b0;
         init_done_q <= 1'b0;
         cmd_q       <= CMD_NOP;
         sd_ba       <= '0;
         sd_a        <= '0;
         sd_dqm      <= '1;
         sd_dq_oe    <= 1'b0;
         sd_dq_out   <= '0;
         r_we        <= 1'b0;
         r_addr      <= '0;
         r_wdata     <= '0;
         r_be        <= '0;
      end else begin
         st_q      <= st_d;
         ret_q     <= ret_d;
         iref_q    <= iref_d;
         if (st_q == ST_LMR) init_done_q <= 1'b1;
         cmd_q     <= cmd_d;
         sd_ba     <= ba_d;
         sd_a      <= a_d;
         sd_dqm    <= dqm_d;
         sd_dq_oe  <= oe_d;
         sd_dq_out <= oe_d ? r_wdata : '0;
         if (accept) begin
            r_we    <= req_we;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
            r_be    <= req_be;
         end
      end
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

   assert_autoprecharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_READ || cmd_q == CMD_WRITE) |-> sd_a[10]);

   assert_read_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_READ) |-> (sd_dqm == '0 && !sd_dq_oe));

   assert_refresh_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && ref_pend) |=> (st_q == ST_REF));

   assert_accept_opens_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (st_q == ST_ACT && !req_ready));

   assert_act_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));

endmodule

// File: tb/tb_sdram_seq_ctrl.sv
module tb_sdram_seq_ctrl;

   localparam int CL    = 2;
   localparam int INIT  = 40;
   localparam int REF   = 150;
   localparam int TRCD  = 2, TRP = 2, TRC = 7, TMRD = 2, TWR = 2;
   localparam int RDG   = (CL + TRP > TRC - TRCD) ? CL + TRP : TRC - TRCD;
   localparam int WRG   = (TWR + TRP > TRC - TRCD) ? TWR + TRP : TRC - TRCD;
   localparam int SLACK = 16;

   localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                          C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                          C_MRS = 4'b0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_we = 1'b0;
   logic [21:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic [3:0]  req_be = '0;
   logic        req_ready, rd_valid;
   logic [31:0] rd_data;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [11:0] sd_a;
   logic [3:0]  sd_dqm;
   logic [31:0] sd_dq_out;
   logic        sd_dq_oe;
   logic [31:0] sd_dq_in = '0;

   always #2 clk = ~clk;

   sdram_seq_ctrl #(
      .CAS_LAT(CL), .INIT_CYC(INIT), .REF_CYC(REF),
      .T_RCD(TRCD), .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD), .T_WR(TWR)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
      .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

   int checks = 0, errors = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard state
   logic [31:0] exp_mem [int];
   logic [31:0] dev_mem [int];
   logic [31:0] rd_q [$];
   logic [21:0] act_q [$];

   // device model state
   int          cyc = 0, init_step = 0, ref_cnt = 0, rd_cnt = 0;
   int          last_act = -1000, last_col = -1000, last_ref = -1000, col_need = 0;
   int          last_rd_cyc = -1000, last_ref_post = -1;
   bit          idle_phase = 1'b0, early_ready = 1'b0;
   bit          open_b [4];
   logic [11:0] open_row [4];
   logic [7:0]  exp_col;
   logic [31:0] rd_word;

   always @(negedge clk) begin
      logic [3:0]  cmd;
      logic [31:0] old, msk;
      int          key;
      if (!rst_n) begin
         cyc = 0;
         for (int b = 0; b < 4; b++) open_b[b] = 1'b0;
      end else begin
         cyc++;
         if (rd_cnt > 0) begin
            rd_cnt--;
            sd_dq_in = (rd_cnt == 0) ? rd_word : (32'hBAD0_0000 ^ cyc);
         end else
            sd_dq_in = 32'hBAD0_0000 ^ cyc;
         cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
         if (sd_dq_oe && cmd != C_WR) chk(0, "R6 bus driven outside WRITE", {28'd0, cmd}, {28'd0, C_WR});
         if (req_ready && init_step < 4 && !early_ready) begin
            early_ready = 1'b1;
            chk(0, "R1 ready before init", 32'd1, 32'd0);
         end
         // scoreboard monitor (R5)
         if (rd_valid) begin
            if (rd_q.size() == 0) chk(0, "R5 unexpected rd_valid", rd_data, 32'd0);
            else begin
               old = rd_q.pop_front();
               chk(rd_data == old, "R5 read data", rd_data, old);
               chk(cyc == last_rd_cyc + CL + 1, "R5 latency", cyc - last_rd_cyc, CL + 1);
            end
         end
         if (!(cmd inside {C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS}))
            chk(0, "R10 illegal command code", {28'd0, cmd}, {28'd0, C_NOP});
         if (cmd != C_NOP && init_step < 4) begin
            case (init_step)
               0: chk(cmd == C_PRE && sd_a[10] && cyc >= INIT, "R1 first cmd precharge-all",
                      {cyc[27:0], cmd}, {INIT[27:0], C_PRE});
               1, 2: chk(cmd == C_REF, "R1 init refresh", {28'd0, cmd}, {28'd0, C_REF});
               default: begin
                  chk(cmd == C_MRS, "R1 mode load last", {28'd0, cmd}, {28'd0, C_MRS});
                  chk(sd_a == 12'(32'h200 | (CL << 4)), "R2 mode word", {20'd0, sd_a},
                      32'h200 | (CL << 4));
               end
            endcase
            init_step++;
         end else if (cmd == C_ACT) begin
            chk(req_ready == 1'b0, "R11 ready low during access", {31'd0, req_ready}, 32'd0);
            chk(cyc - last_col >= col_need, "R8 column to ACTIVE gap", cyc - last_col, col_need);
            chk(cyc - last_act >= TRC && cyc - last_ref >= TRC, "R8 ACTIVE spacing",
                cyc - last_ref, TRC);
            if (act_q.size() == 0) chk(0, "R3 ACTIVE without request", {30'd0, sd_ba}, 32'd0);
            else begin
               old = {10'd0, act_q.pop_front()};
               chk(sd_ba == old[21:20] && sd_a == old[19:8], "R3 bank/row", {18'd0, sd_ba, sd_a},
                   {18'd0, old[21:8]});
               exp_col = old[7:0];
            end
            open_b[sd_ba] = 1'b1;
            open_row[sd_ba] = sd_a;
            last_act = cyc;
         end else if (cmd == C_RD || cmd == C_WR) begin
            chk(open_b[sd_ba], "R3 column to open bank", {30'd0, sd_ba}, 32'd0);
            chk(sd_a[7:0] == exp_col, "R3 column", {24'd0, sd_a[7:0]}, {24'd0, exp_col});
            chk(sd_a[10] && (sd_a & 12'hB00) == 12'h0, "R4 auto-precharge field", {20'd0, sd_a},
                {20'd0, 12'h400 | {4'd0, exp_col}});
            chk(cyc - last_act >= TRCD, "R8 ACTIVE to column gap", cyc - last_act, TRCD);
            key = {8'd0, sd_ba, open_row[sd_ba], sd_a[7:0]};
            old = dev_mem.exists(key) ? dev_mem[key] : 32'h0;
            if (cmd == C_WR) begin
               chk(sd_dq_oe, "R6 bus driven on WRITE", {31'd0, sd_dq_oe}, 32'd1);
               msk = {{8{~sd_dqm[3]}}, {8{~sd_dqm[2]}}, {8{~sd_dqm[1]}}, {8{~sd_dqm[0]}}};
               dev_mem[key] = (old & ~msk) | (sd_dq_out & msk);
               col_need = WRG;
            end else begin
               chk(sd_dqm == 4'h0 && !sd_dq_oe, "R7 read unmasked", {27'd0, sd_dq_oe, sd_dqm}, 32'd0);
               rd_word = old;
               rd_cnt = CL;
               last_rd_cyc = cyc;
               col_need = RDG;
            end
            open_b[sd_ba] = 1'b0;
            last_col = cyc;
         end else if (cmd == C_REF) begin
            chk(cyc - last_col >= col_need && cyc - last_act >= TRC, "R8 refresh spacing",
                cyc - last_col, col_need);
            if (last_ref_post >= 0) begin
               if (idle_phase)
                  chk(cyc - last_ref_post == REF, "R9 idle refresh period", cyc - last_ref_post, REF);
               else
                  chk(cyc - last_ref_post <= REF + SLACK, "R9 refresh overdue",
                      cyc - last_ref_post, REF + SLACK);
            end
            last_ref_post = cyc;
            last_ref = cyc;
            ref_cnt++;
         end else if (cmd != C_NOP) begin
            chk(0, "R10 unexpected command after init", {28'd0, cmd}, {28'd0, C_NOP});
         end
      end
   end

   task automatic do_req(input bit we, input logic [21:0] addr, input logic [31:0] d,
                         input logic [3:0] be);
      logic [31:0] old, msk;
      old = exp_mem.exists(int'(addr)) ? exp_mem[int'(addr)] : 32'h0;
      act_q.push_back(addr);
      if (we) begin
         msk = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
         exp_mem[int'(addr)] = (old & ~msk) | (d & msk);
      end else
         rd_q.push_back(old);
      req_we = we; req_addr = addr; req_wdata = d; req_be = be; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int r0, t;
      logic [21:0] a;
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0 && rd_valid == 1'b0, "R1 reset outputs", {30'd0, req_ready, rd_valid}, 32'd0);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 reset NOP",
          {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, {28'd0, C_NOP});
      rst_n = 1'b1;
      while (init_step < 4) @(negedge clk);
      while (!req_ready) @(negedge clk);
      chk(init_step == 4, "R1 init complete before ready", init_step, 4);

      // corner addresses across banks, full-word writes
      do_req(1, 22'h000000, 32'h1111_2222, 4'hF);
      do_req(1, 22'h3FFFFF, 32'hA5A5_5A5A, 4'hF);
      do_req(1, 22'h1ABC12, 32'hCAFE_0001, 4'hF);
      do_req(1, 22'h2001FF, 32'h0BAD_F00D, 4'hF);
      do_req(0, 22'h000000, 32'h0, 4'h0);
      do_req(0, 22'h3FFFFF, 32'h0, 4'h0);
      do_req(0, 22'h1ABC12, 32'h0, 4'h0);
      do_req(0, 22'h2001FF, 32'h0, 4'h0);
      // byte-lane masking (R6)
      do_req(1, 22'h1ABC12, 32'h7788_99AA, 4'b0101);
      do_req(1, 22'h3FFFFF, 32'h0000_00EE, 4'b0001);
      do_req(0, 22'h1ABC12, 32'h0, 4'h0);
      do_req(0, 22'h3FFFFF, 32'h0, 4'h0);
      do_req(0, 22'h155555, 32'h0, 4'h0);   // never written

      // idle refresh period (R9)
      r0 = ref_cnt; t = 0;
      while (ref_cnt < r0 + 2 && t < 5 * REF) begin @(negedge clk); t++; end
      idle_phase = 1'b1;
      t = 0;
      while (ref_cnt < r0 + 3 && t < 3 * REF) begin @(negedge clk); t++; end
      idle_phase = 1'b0;
      chk(ref_cnt >= r0 + 3, "R9 refreshes while idle", ref_cnt - r0, 3);

      // request stream crossing refresh intervals
      for (int i = 0; i < 60; i++) begin
         a = 22'((i * 32'h0002_5A3B) ^ (i << 17));
         do_req(i % 3 != 2, a, 32'h1357_0000 + i, 4'(i % 16) | 4'h1);
         if (i % 3 == 2) do_req(0, 22'((i - 1) * 32'h0002_5A3B ^ ((i - 1) << 17)), 0, 0);
      end

      t = 0;
      while ((rd_q.size() != 0 || act_q.size() != 0) && t < 200) begin @(negedge clk); t++; end
      chk(rd_q.size() == 0, "R5 all reads returned", rd_q.size(), 0);
      chk(act_q.size() == 0, "R3 all requests issued", act_q.size(), 0);
      chk(ref_cnt >= 6, "R9 refresh count", ref_cnt, 6);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule